// File: doc/BRIEF.md
# USB Endpoint Buffer Allocator

This block divides a single 256-byte packet memory among the endpoints of a full-speed USB device. Endpoint 0 is the control endpoint. It serves both directions and always owns the first 64 bytes of the memory. Three more slots can each be turned on. Each slot is given its own direction, USB endpoint number, maximum packet size, buffer count and transfer type. From these settings the block works out a memory map at run time. It registers that map, along with a configuration-error flag, one clock after the settings change.

When the protocol engine presents a token, the block looks up the endpoint number and direction against the registered map. One clock later it returns a response. A hit carries the base address and allowed length inside the memory. A no-match tells the engine to stall.

A slot can be double-buffered, in which case it owns two halves. A ping-pong bit per slot picks the half the USB side uses, and the CPU side is shown the other half. That bit flips only when the engine reports a successful transaction-complete after a hit on that slot.

Top module: `usb_ep_buf_alloc`

## Requirements
- R1: A token with endpoint number 0, in either direction, hits with base 0 and length 64. This holds even while the configuration error is set.
- R2: A token hits an enabled slot when its number and direction match that slot, where cfg_dir_in bit = 1 means IN. The returned length is 8 << code, where code is the slot's 2-bit size field: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R3: Slot regions are packed in slot order starting at address 64. Each base is 64 plus the sizes of the enabled lower slots. A disabled slot takes no space. A double-buffered slot takes twice its packet size.
- R4: cfg_err is set one clock after the configuration changes if 64 plus the total slot allocation exceeds 256. A total of exactly 256 is accepted.
- R5: cfg_err is set when two enabled slots share both endpoint number and direction. The same number with opposite directions is accepted, and disabled slots are not compared.
- R6: cfg_type is 2 bits per slot: 2 means bulk, 3 means interrupt, 1 means isochronous and 0 means control. An enabled slot with type 0 or 1, or with endpoint number 0, sets cfg_err.
- R7: While cfg_err is set, every slot is treated as disabled. Tokens for non-zero endpoint numbers then give no-match.
- R8: A token matching no enabled slot gives rsp_nomatch = 1 and rsp_hit = 0, with rsp_base and rsp_len both 0.
- R9: The response is registered. rsp_valid is high in the single cycle after the clock edge that sampled tok_valid, and is low otherwise.
- R10: In a double-buffered slot with ping-pong bit p, a hit returns base + p × packet size. cpu_half bit i is the inverse of p for an enabled double-buffered slot, and 0 for any other slot.
- R11: The ping-pong bit of a slot toggles only on a cycle with xfer_done = 1 and xfer_ok = 1, and only if the most recent token hit that double-buffered slot. At most one toggle happens per token. A pulse with xfer_ok = 0, or one after a hit on a single-buffered slot, endpoint 0 or a no-match, changes nothing.
- R12: After reset, rsp_valid, rsp_hit, rsp_nomatch, cfg_err and cpu_half are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 3 | Slot enable, one bit per slot |
| cfg_dir_in | input | 3 | Slot direction, 1 = IN |
| cfg_dbuf | input | 3 | Slot double-buffer select |
| cfg_psize | input | 6 | 2-bit packet size code per slot |
| cfg_epnum | input | 12 | 4-bit USB endpoint number per slot |
| cfg_type | input | 6 | 2-bit transfer type per slot |
| tok_valid | input | 1 | Token present this cycle |
| tok_epnum | input | 4 | Token endpoint number |
| tok_dir_in | input | 1 | Token direction, 1 = IN |
| xfer_done | input | 1 | Transaction-complete pulse |
| xfer_ok | input | 1 | Transaction completed successfully |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Token matched an endpoint |
| rsp_nomatch | output | 1 | Token matched nothing (stall) |
| rsp_base | output | 8 | Buffer base address for the USB side |
| rsp_len | output | 7 | Allowed packet length |
| cfg_err | output | 1 | Configuration does not fit or is illegal |
| cpu_half | output | 3 | Half currently owned by the CPU side, per slot |

## Verification
The assertions assume three things about the inputs. The configuration is not changed in the same cycle as a token, because the response and cfg_err would then describe different maps. xfer_done follows the token it completes. No token arrives while the synchronized reset is still low.

The directed bench keeps within these limits. It changes the configuration only between tokens and then idles one clock. It pulses xfer_done only after a checked response. It waits several cycles after reset before sending any stimulus.

// File: rtl/usb_eba_pkg.sv
package usb_eba_pkg;
  localparam int NSLOT      = 3;
  localparam int SRAM_BYTES = 256;
  localparam int EP0_BYTES  = 64;
  localparam int MIN_PKT    = 8;
  localparam int NUM_W      = 4;
  localparam int PSZ_W      = 2;
  localparam int TYPE_W     = 2;
  localparam int AW         = $clog2(SRAM_BYTES);
  localparam int TW         = AW + 3;
  localparam int LEN_W      = $clog2(EP0_BYTES) + 1;
  localparam int SLOT_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  typedef enum logic [TYPE_W-1:0] {
    XT_CTRL = 2'd0,
    XT_ISO  = 2'd1,
    XT_BULK = 2'd2,
    XT_INTR = 2'd3
  } xfer_type_t;

  typedef struct packed {
    logic             en;
    logic             dir_in;
    logic             dbuf;
    logic [NUM_W-1:0] num;
    logic [LEN_W-1:0] mps;
    logic [TW-1:0]    base;
  } slot_t;
endpackage

// File: rtl/ep_layout.sv
module ep_layout
  import usb_eba_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOT-1:0]         cfg_en,
  input  logic [NSLOT-1:0]         cfg_dir_in,
  input  logic [NSLOT-1:0]         cfg_dbuf,
  input  logic [NSLOT*PSZ_W-1:0]   cfg_psize,
  input  logic [NSLOT*NUM_W-1:0]   cfg_epnum,
  input  logic [NSLOT*TYPE_W-1:0]  cfg_type,
  output slot_t [NSLOT-1:0]        lay_q,
  output logic                     err_q
);
  slot_t [NSLOT-1:0] lay_d;
  logic              err_d;
  logic [LEN_W-1:0]  mps_c  [NSLOT];
  logic [TW-1:0]     base_c [NSLOT];
  logic [TW-1:0]     run;
  logic              over, dup, bad;

  always_comb begin
    run = TW'(EP0_BYTES);
    dup = 1'b0;
    bad = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      mps_c[i]  = LEN_W'(MIN_PKT) << cfg_psize[i*PSZ_W +: PSZ_W];
      base_c[i] = run;
      if (cfg_en[i]) begin
        run = run + (cfg_dbuf[i] ? (TW'(mps_c[i]) << 1) : TW'(mps_c[i]));
        if ((cfg_type[i*TYPE_W +: TYPE_W] == XT_CTRL) ||
            (cfg_type[i*TYPE_W +: TYPE_W] == XT_ISO)  ||
            (cfg_epnum[i*NUM_W +: NUM_W] == '0))
          bad = 1'b1;
      end
      for (int j = 0; j < i; j++) begin
        if (cfg_en[i] && cfg_en[j] &&
            (cfg_epnum[i*NUM_W +: NUM_W] == cfg_epnum[j*NUM_W +: NUM_W]) &&
            (cfg_dir_in[i] == cfg_dir_in[j]))
          dup = 1'b1;
      end
    end
    over  = run > TW'(SRAM_BYTES);
    err_d = over | dup | bad;
    for (int i = 0; i < NSLOT; i++) begin
      lay_d[i].en     = cfg_en[i] & ~err_d;
      lay_d[i].dir_in = cfg_dir_in[i];
      lay_d[i].dbuf   = cfg_dbuf[i] & cfg_en[i] & ~err_d;
      lay_d[i].num    = cfg_epnum[i*NUM_W +: NUM_W];
      lay_d[i].mps    = mps_c[i];
      lay_d[i].base   = base_c[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lay_q <= '0;
      err_q <= 1'b0;
    end else begin
      lay_q <= lay_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/ep_match.sv
module ep_match
  import usb_eba_pkg::*;
(
  input  slot_t [NSLOT-1:0]  lay,
  input  logic [NSLOT-1:0]   pp,
  input  logic [NUM_W-1:0]   tok_num,
  input  logic               tok_dir_in,
  output logic               m_hit,
  output logic               m_ep0,
  output logic [SLOT_W-1:0]  m_slot,
  output logic [TW-1:0]      m_base,
  output logic [LEN_W-1:0]   m_len
);
  always_comb begin
    m_hit  = 1'b0;
    m_ep0  = 1'b0;
    m_slot = '0;
    m_base = '0;
    m_len  = '0;
    if (tok_num == '0) begin
      m_hit = 1'b1;
      m_ep0 = 1'b1;
      m_len = LEN_W'(EP0_BYTES);
    end else begin
      for (int i = NSLOT - 1; i >= 0; i--) begin
        if (lay[i].en && (lay[i].num == tok_num) && (lay[i].dir_in == tok_dir_in)) begin
          m_hit  = 1'b1;
          m_slot = SLOT_W'(i);
          m_len  = lay[i].mps;
          m_base = lay[i].base + ((lay[i].dbuf && pp[i]) ? TW'(lay[i].mps) : '0);
        end
      end
    end
  end
endmodule

// File: rtl/ep_pingpong.sv
module ep_pingpong
  import usb_eba_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] tog,
  output logic [NSLOT-1:0] pp_q
);
  logic [NSLOT-1:0] pp_d;

  for (genvar g = 0; g < NSLOT; g++) begin : g_pp
    assign pp_d[g] = ~pp_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pp_q[g] <= 1'b0;
      else if (tog[g])
        pp_q[g] <= pp_d[g];
    end
  end
endmodule

// File: rtl/usb_ep_buf_alloc.sv
module usb_ep_buf_alloc
  import usb_eba_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOT-1:0]         cfg_en,
  input  logic [NSLOT-1:0]         cfg_dir_in,
  input  logic [NSLOT-1:0]         cfg_dbuf,
  input  logic [NSLOT*PSZ_W-1:0]   cfg_psize,
  input  logic [NSLOT*NUM_W-1:0]   cfg_epnum,
  input  logic [NSLOT*TYPE_W-1:0]  cfg_type,
  input  logic                     tok_valid,
  input  logic [NUM_W-1:0]         tok_epnum,
  input  logic                     tok_dir_in,
  input  logic                     xfer_done,
  input  logic                     xfer_ok,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_nomatch,
  output logic [AW-1:0]            rsp_base,
  output logic [LEN_W-1:0]         rsp_len,
  output logic                     cfg_err,
  output logic [NSLOT-1:0]         cpu_half
);
  logic [1:0] rst_ff;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  slot_t [NSLOT-1:0] lay_q;
  logic [NSLOT-1:0]  pp_q;
  logic [NSLOT-1:0]  tog;
  logic              m_hit, m_ep0;
  logic [SLOT_W-1:0] m_slot;
  logic [TW-1:0]     m_base;
  logic [LEN_W-1:0]  m_len;

  ep_layout u_layout (
    .clk(clk), .rst_n(rst_sync_n),
    .cfg_en(cfg_en), .cfg_dir_in(cfg_dir_in), .cfg_dbuf(cfg_dbuf),
    .cfg_psize(cfg_psize), .cfg_epnum(cfg_epnum), .cfg_type(cfg_type),
    .lay_q(lay_q), .err_q(cfg_err)
  );

  ep_match u_match (
    .lay(lay_q), .pp(pp_q), .tok_num(tok_epnum), .tok_dir_in(tok_dir_in),
    .m_hit(m_hit), .m_ep0(m_ep0), .m_slot(m_slot), .m_base(m_base), .m_len(m_len)
  );

  ep_pingpong u_pp (
    .clk(clk), .rst_n(rst_sync_n), .tog(tog), .pp_q(pp_q)
  );

  logic              rsp_valid_d, rsp_hit_d, rsp_nomatch_d;
  logic [AW-1:0]     rsp_base_d;
  logic [LEN_W-1:0]  rsp_len_d;
  logic              last_valid_q, last_valid_d;
  logic [SLOT_W-1:0] last_slot_q, last_slot_d;

  always_comb begin
    rsp_valid_d   = tok_valid;
    rsp_hit_d     = tok_valid & m_hit;
    rsp_nomatch_d = tok_valid & ~m_hit;
    rsp_base_d    = (tok_valid & m_hit) ? m_base[AW-1:0] : '0;
    rsp_len_d     = (tok_valid & m_hit) ? m_len : '0;
    last_valid_d  = last_valid_q;
    last_slot_d   = last_slot_q;
    tog           = '0;
    if (xfer_done) begin
      last_valid_d = 1'b0;
      for (int i = 0; i < NSLOT; i++)
        if (xfer_ok && last_valid_q && (last_slot_q == SLOT_W'(i)) && lay_q[i].dbuf)
          tog[i] = 1'b1;
    end
    if (tok_valid) begin
      last_valid_d = m_hit & ~m_ep0;
      last_slot_d  = m_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_nomatch  <= 1'b0;
      rsp_base     <= '0;
      rsp_len      <= '0;
      last_valid_q <= 1'b0;
      last_slot_q  <= '0;
    end else begin
      rsp_valid    <= rsp_valid_d;
      rsp_hit      <= rsp_hit_d;
      rsp_nomatch  <= rsp_nomatch_d;
      rsp_base     <= rsp_base_d;
      rsp_len      <= rsp_len_d;
      last_valid_q <= last_valid_d;
      last_slot_q  <= last_slot_d;
    end
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      cpu_half[i] = lay_q[i].dbuf & ~pp_q[i];
  end
endmodule

// File: rtl/usb_eba_chk.sv
module usb_eba_chk
  import usb_eba_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tok_valid,
  input logic             xfer_done,
  input logic             xfer_ok,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_nomatch,
  input logic [AW-1:0]    rsp_base,
  input logic [LEN_W-1:0] rsp_len,
  input logic             cfg_err,
  input logic [NSLOT-1:0] pp_q
);
  p_rsp_follows_tok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> rsp_valid);
  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !rsp_valid);
  p_hit_xor_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_nomatch));
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nomatch) |-> (rsp_base == '0 && rsp_len == '0));
  p_in_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> ((TW'(rsp_base) + TW'(rsp_len)) <= TW'(SRAM_BYTES)));
  p_len_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_len));
  p_err_ep0_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && rsp_valid && rsp_hit) |-> (rsp_base == '0 && rsp_len == LEN_W'(EP0_BYTES)));
  p_pp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && xfer_ok) |=> $stable(pp_q));
  p_pp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pp_q ^ $past(pp_q)) <= 1);
endmodule

bind usb_ep_buf_alloc usb_eba_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tok_valid(tok_valid), .xfer_done(xfer_done),
  .xfer_ok(xfer_ok), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_nomatch(rsp_nomatch), .rsp_base(rsp_base), .rsp_len(rsp_len),
  .cfg_err(cfg_err), .pp_q(pp_q)
);

// File: tb/tb_usb_ep_buf_alloc.sv
module tb_usb_ep_buf_alloc;
  logic        clk, rst_n;
  logic [2:0]  cfg_en, cfg_dir_in, cfg_dbuf;
  logic [5:0]  cfg_psize, cfg_type;
  logic [11:0] cfg_epnum;
  logic        tok_valid, tok_dir_in, xfer_done, xfer_ok;
  logic [3:0]  tok_epnum;
  logic        rsp_valid, rsp_hit, rsp_nomatch, cfg_err;
  logic [7:0]  rsp_base;
  logic [6:0]  rsp_len;
  logic [2:0]  cpu_half;
  int n_chk, n_bad;
  bit done_flag;

  usb_ep_buf_alloc dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic slot(input int i, input bit en, input bit din, input int psz,
                      input int num, input bit db, input int ty);
    cfg_en[i] = en; cfg_dir_in[i] = din; cfg_dbuf[i] = db;
    cfg_psize[i*2 +: 2] = 2'(psz);
    cfg_epnum[i*4 +: 4] = 4'(num);
    cfg_type[i*2 +: 2]  = 2'(ty);
  endtask

  task automatic apply();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic token(input string tag, input int num, input bit din,
                       input bit ehit, input int ebase, input int elen);
    @(negedge clk);
    tok_valid = 1'b1; tok_epnum = 4'(num); tok_dir_in = din;
    @(negedge clk);
    tok_valid = 1'b0;
    chk({tag, " R9 valid"}, rsp_valid, 1);
    chk({tag, " hit"}, rsp_hit, ehit);
    chk({tag, " R8 nomatch"}, rsp_nomatch, !ehit);
    chk({tag, " base"}, rsp_base, ebase);
    chk({tag, " len"}, rsp_len, elen);
  endtask

  task automatic done(input bit ok);
    @(negedge clk);
    xfer_done = 1'b1; xfer_ok = ok;
    @(negedge clk);
    xfer_done = 1'b0; xfer_ok = 1'b0;
  endtask

  task automatic cfg_a();
    slot(0, 1, 1, 3, 1, 0, 2);
    slot(1, 1, 0, 1, 2, 1, 2);
    slot(2, 1, 1, 0, 3, 0, 3);
    apply();
  endtask

  task automatic t_reset();
    chk("R12 rsp_valid", rsp_valid, 0);
    chk("R12 rsp_hit", rsp_hit, 0);
    chk("R12 rsp_nomatch", rsp_nomatch, 0);
    chk("R12 cfg_err", cfg_err, 0);
    chk("R12 cpu_half", cpu_half, 0);
  endtask

  task automatic t_layout();
    cfg_a();
    chk("R3 cfg_err A", cfg_err, 0);
    token("R2 ep1 in", 1, 1, 1, 64, 64);
    token("R3 ep2 out", 2, 0, 1, 128, 16);
    token("R3 ep3 in", 3, 1, 1, 160, 8);
    token("R8 ep3 out", 3, 0, 0, 0, 0);
    token("R8 ep5 in", 5, 1, 0, 0, 0);
    token("R1 ep0 out", 0, 0, 1, 0, 64);
    token("R1 ep0 in", 0, 1, 1, 0, 64);
    @(negedge clk);
    chk("R9 valid drops", rsp_valid, 0);
  endtask

  task automatic t_gap();
    cfg_a();
    slot(0, 0, 1, 3, 1, 0, 2);
    apply();
    token("R3 gap ep2 out", 2, 0, 1, 64, 16);
    token("R3 gap ep3 in", 3, 1, 1, 96, 8);
    token("R3 gap ep1 off", 1, 1, 0, 0, 0);
    slot(1, 1, 0, 2, 2, 0, 2);
    apply();
    token("R2 size32", 2, 0, 1, 64, 32);
  endtask

  task automatic t_fit();
    slot(0, 1, 1, 3, 1, 1, 2);
    slot(1, 1, 0, 3, 2, 0, 2);
    slot(2, 0, 1, 0, 3, 0, 2);
    apply();
    chk("R4 exact fit err", cfg_err, 0);
    token("R4 exact fit ep2", 2, 0, 1, 192, 64);
    slot(1, 1, 0, 3, 2, 1, 2);
    apply();
    chk("R4 overflow err", cfg_err, 1);
    token("R7 err ep2", 2, 0, 0, 0, 0);
    token("R7 err ep1", 1, 1, 0, 0, 0);
    token("R7 err ep0", 0, 1, 1, 0, 64);
    chk("R7 cpu_half err", cpu_half, 0);
  endtask

  task automatic t_dup();
    slot(0, 1, 1, 0, 4, 0, 2);
    slot(1, 1, 0, 0, 4, 0, 3);
    slot(2, 0, 1, 0, 4, 0, 2);
    apply();
    chk("R5 opposite dir ok", cfg_err, 0);
    token("R5 ep4 out", 4, 0, 1, 72, 8);
    slot(1, 1, 1, 0, 4, 0, 3);
    apply();
    chk("R5 dup err", cfg_err, 1);
    token("R7 dup ep4", 4, 1, 0, 0, 0);
  endtask

  task automatic t_type();
    slot(0, 1, 1, 0, 1, 0, 1);
    slot(1, 0, 0, 0, 2, 0, 2);
    slot(2, 0, 0, 0, 3, 0, 2);
    apply();
    chk("R6 iso err", cfg_err, 1);
    slot(0, 1, 1, 0, 1, 0, 0);
    apply();
    chk("R6 ctrl err", cfg_err, 1);
    slot(0, 1, 1, 0, 0, 0, 3);
    apply();
    chk("R6 num0 err", cfg_err, 1);
    slot(0, 1, 1, 0, 1, 0, 3);
    apply();
    chk("R6 intr ok", cfg_err, 0);
    token("R6 intr ep1", 1, 1, 1, 64, 8);
  endtask

  task automatic t_pingpong();
    cfg_a();
    chk("R10 cpu_half init", cpu_half, 3'b010);
    token("R10 pp0", 2, 0, 1, 128, 16);
    done(1);
    chk("R11 toggle", cpu_half, 3'b000);
    token("R10 pp1", 2, 0, 1, 144, 16);
    done(0);
    chk("R11 not ok", cpu_half, 3'b000);
    token("R11 single", 1, 1, 1, 64, 64);
    done(1);
    chk("R11 single no toggle", cpu_half, 3'b000);
    token("R11 miss", 5, 0, 0, 0, 0);
    done(1);
    chk("R11 miss no toggle", cpu_half, 3'b000);
    token("R11 ep0", 0, 0, 1, 0, 64);
    done(1);
    chk("R11 ep0 no toggle", cpu_half, 3'b000);
    token("R11 again", 2, 0, 1, 144, 16);
    done(1);
    chk("R11 toggle back", cpu_half, 3'b010);
    done(1);
    chk("R11 once per token", cpu_half, 3'b010);
    token("R10 back pp0", 2, 0, 1, 128, 16);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done_flag = 0;
    rst_n = 1'b0;
    cfg_en = '0; cfg_dir_in = '0; cfg_dbuf = '0;
    cfg_psize = '0; cfg_type = '0; cfg_epnum = '0;
    tok_valid = 0; tok_epnum = '0; tok_dir_in = 0; xfer_done = 0; xfer_ok = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_layout();
    t_gap();
    t_fit();
    t_dup();
    t_type();
    t_pingpong();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule